// File: doc/BRIEF.md
# Hypervisor-Aware Local Interrupt Router

This block sits beside the trap logic of a hart that implements the hypervisor extension. Every cycle it looks at the pending and enabled local interrupt lines, the two delegation masks, the current privilege level, the virtualization flag and the active global interrupt-enable bits. From these it decides three things: whether an interrupt must be taken now, which cause number wins, and which of the three handling levels (machine, hypervisor-supervisor or virtual-supervisor) receives it.

Each interrupt line belongs to exactly one handling tier. The machine delegation mask moves a line down from machine level. The hypervisor delegation mask then moves it further down to the guest level. A line is taken only when its tier's global enable is true. For the purpose of these enables, the hypervisor-supervisor level ranks above both guest levels. The guest-level lines (software 2, timer 6, external 10) are ordinary candidates even outside virtualization unless they are delegated, and no forced path to the hypervisor level exists. The decision can be registered for one clock so that it meets timing at the trap-entry stage.

Top module: `hyp_irq_router`

## Requirements
- R1: A line is a candidate only when both its pending bit and its enable bit are 1. Lines 2, 6 and 10 receive no special masking, so with virtualization off they are taken at machine or hypervisor level whenever their tier allows it.
- R2: The machine-tier enable is true when the privilege code is U (00) or S (01). It is also true when the code is M (11) and the MIE input is 1.
- R3: The hypervisor-tier enable is true when virtualization is on. It is also true when the privilege code is U, or when the code is S and the SIE input is 1. With virtualization off at privilege M it is false.
- R4: The guest-tier enable is true only when virtualization is on and either the privilege code is U, or the code is S and SIE is 1.
- R5: The machine delegation mask and the hypervisor delegation mask together assign each line to one tier:
  - a line with a 0 in the machine mask uses the machine tier;
  - a line with a 1 in the machine mask and a 0 in the hypervisor mask uses the hypervisor tier;
  - a line with a 1 in both masks uses the guest tier;
  - a hypervisor mask bit without the matching machine mask bit has no effect.
- R6: Among all qualified lines from all tiers, the lowest-numbered one is selected and its index is driven on the cause output.
- R7: The target output gives the tier of the selected line: 2'b11 machine, 2'b01 hypervisor, 2'b10 guest.
- R8: When no line qualifies, the take flag is 0 and the cause and target outputs are 0.
- R9: The privilege code 10 enables no tier, so no interrupt is taken.
- R10: With the output register enabled (the default), the outputs show the decision for the inputs sampled at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_pend_i | input | IRQ_W (16) | Pending interrupt lines |
| irq_en_i | input | IRQ_W (16) | Per-line interrupt enables |
| mdeleg_i | input | IRQ_W (16) | Machine delegation mask |
| hdeleg_i | input | IRQ_W (16) | Hypervisor delegation mask |
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M, 10 none |
| virt_i | input | 1 | Virtualization mode active |
| mie_i | input | 1 | Active machine global interrupt enable |
| sie_i | input | 1 | Active supervisor global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | $clog2(IRQ_W) (4) | Index of the selected line |
| target_o | output | 2 | Handling tier: 11 M, 01 HS, 10 VS, 00 none |

## Verification
Every cycle, the assertions check the following against the inputs behind the outputs: a taken cause is pending and enabled, and the reported tier agrees with the delegation masks. They also check that a guest-tier target only appears under virtualization, that machine-tier takes at privilege M require MIE, and that the idle outputs are zero. They cannot tell whether the lowest qualified line was chosen, or whether an interrupt that should fire was wrongly held back. The directed scenarios show these by hand-computed outcomes: the enable boundaries of each tier, guest lines outside virtualization, mixed-tier priority, the one-cycle output latency, and a sweep against an independent model.

// File: rtl/hir_pkg.sv
package hir_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_NONE = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_HS   = 2'b01,
    TGT_VS   = 2'b10,
    TGT_M    = 2'b11
  } tgt_e;

  // Per-tier global enables after privilege and virtualization are applied
  typedef struct packed {
    logic m;
    logic hs;
    logic vs;
  } tier_gate_t;

endpackage

// File: rtl/hir_tier_gates.sv
module hir_tier_gates
  import hir_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       mie_i,
  input  logic       sie_i,
  output tier_gate_t gates_o
);

  priv_e priv;
  assign priv = priv_e'(priv_i);

  always_comb begin
    gates_o = '0;
    unique case (priv)
      PRIV_U: begin
        gates_o.m  = 1'b1;
        gates_o.hs = 1'b1;
        gates_o.vs = virt_i;
      end
      PRIV_S: begin
        gates_o.m  = 1'b1;
        gates_o.hs = virt_i | sie_i;
        gates_o.vs = virt_i & sie_i;
      end
      PRIV_M: begin
        gates_o.m  = mie_i;
        gates_o.hs = virt_i;
        gates_o.vs = 1'b0;
      end
      default: gates_o = '0;
    endcase
  end

endmodule

// File: rtl/hir_qualify.sv
module hir_qualify
  import hir_pkg::*;
#(
  parameter int IRQ_W = 16
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] en_i,
  input  logic [IRQ_W-1:0] mdeleg_i,
  input  logic [IRQ_W-1:0] hdeleg_i,
  input  tier_gate_t       gates_i,
  output logic [IRQ_W-1:0] m_grp_o,
  output logic [IRQ_W-1:0] hs_grp_o,
  output logic [IRQ_W-1:0] vs_grp_o
);

  logic [IRQ_W-1:0] cand;
  assign cand = pend_i & en_i;

  always_comb begin
    m_grp_o  = cand & ~mdeleg_i            & {IRQ_W{gates_i.m}};
    hs_grp_o = cand &  mdeleg_i & ~hdeleg_i & {IRQ_W{gates_i.hs}};
    vs_grp_o = cand &  mdeleg_i &  hdeleg_i & {IRQ_W{gates_i.vs}};
  end

endmodule

// File: rtl/hir_lsb_pick.sv
module hir_lsb_pick #(
  parameter int VEC_W = 16,
  localparam int IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VEC_W-1:0] onehot_o
);

  // seen[k] is set when any bit below k is set
  logic [VEC_W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < VEC_W; g++) begin : g_chain
    assign seen[g+1]   = seen[g] | vec_i[g];
    assign onehot_o[g] = vec_i[g] & ~seen[g];
  end

  assign valid_o = seen[VEC_W];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/hir_out_stage.sv
module hir_out_stage #(
  parameter int  CAUSE_W = 4,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_d,
  input  logic [CAUSE_W-1:0] cause_d,
  input  logic [1:0]         target_d,
  output logic               take_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [1:0]         target_q
);

  if (REG_OUT) begin : g_reg
    logic cap_en;
    assign cap_en = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        take_q   <= 1'b0;
        cause_q  <= '0;
        target_q <= 2'b00;
      end else if (cap_en) begin
        take_q   <= take_d;
        cause_q  <= cause_d;
        target_q <= target_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign take_q   = take_d;
    assign cause_q  = cause_d;
    assign target_q = target_d;
  end

endmodule

// File: rtl/hyp_irq_router.sv
module hyp_irq_router
  import hir_pkg::*;
#(
  parameter int IRQ_W   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CAUSE_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IRQ_W-1:0]   irq_pend_i,
  input  logic [IRQ_W-1:0]   irq_en_i,
  input  logic [IRQ_W-1:0]   mdeleg_i,
  input  logic [IRQ_W-1:0]   hdeleg_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [1:0]         target_o
);

  tier_gate_t       gates;
  logic [IRQ_W-1:0] m_grp, hs_grp, vs_grp;
  logic [IRQ_W-1:0] any_grp, pick_oh;
  logic             pick_valid;
  logic [CAUSE_W-1:0] pick_idx;

  logic               take_d;
  logic [CAUSE_W-1:0] cause_d;
  tgt_e               target_d;

  hir_tier_gates u_gates (
    .priv_i (priv_i),
    .virt_i (virt_i),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .gates_o(gates)
  );

  hir_qualify #(.IRQ_W(IRQ_W)) u_qual (
    .pend_i  (irq_pend_i),
    .en_i    (irq_en_i),
    .mdeleg_i(mdeleg_i),
    .hdeleg_i(hdeleg_i),
    .gates_i (gates),
    .m_grp_o (m_grp),
    .hs_grp_o(hs_grp),
    .vs_grp_o(vs_grp)
  );

  assign any_grp = m_grp | hs_grp | vs_grp;

  hir_lsb_pick #(.VEC_W(IRQ_W)) u_pick (
    .vec_i   (any_grp),
    .valid_o (pick_valid),
    .idx_o   (pick_idx),
    .onehot_o(pick_oh)
  );

  // Next-state decision
  always_comb begin
    take_d   = pick_valid;
    cause_d  = pick_valid ? pick_idx : '0;
    target_d = TGT_NONE;
    if (|(pick_oh & m_grp))       target_d = TGT_M;
    else if (|(pick_oh & hs_grp)) target_d = TGT_HS;
    else if (|(pick_oh & vs_grp)) target_d = TGT_VS;
  end

  hir_out_stage #(.CAUSE_W(CAUSE_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_d  (take_d),
    .cause_d (cause_d),
    .target_d(target_d),
    .take_q  (take_o),
    .cause_q (cause_o),
    .target_q(target_o)
  );

endmodule

// File: rtl/hir_route_chk.sv
module hir_route_chk #(
  parameter int IRQ_W   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CAUSE_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IRQ_W-1:0]   irq_pend_i,
  input logic [IRQ_W-1:0]   irq_en_i,
  input logic [IRQ_W-1:0]   mdeleg_i,
  input logic [IRQ_W-1:0]   hdeleg_i,
  input logic [1:0]         priv_i,
  input logic               virt_i,
  input logic               mie_i,
  input logic               sie_i,
  input logic               take_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [1:0]         target_o
);

  // Inputs as seen by the current outputs
  logic [IRQ_W-1:0] s_cand, s_md, s_hd;
  logic [1:0]       s_priv;
  logic             s_virt, s_mie, s_sie, s_ok;

  if (REG_OUT) begin : g_lag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_ok <= 1'b0;
      end else begin
        s_ok <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      s_cand <= irq_pend_i & irq_en_i;
      s_md   <= mdeleg_i;
      s_hd   <= hdeleg_i;
      s_priv <= priv_i;
      s_virt <= virt_i;
      s_mie  <= mie_i;
      s_sie  <= sie_i;
    end
  end else begin : g_now
    assign s_ok   = 1'b1;
    assign s_cand = irq_pend_i & irq_en_i;
    assign s_md   = mdeleg_i;
    assign s_hd   = hdeleg_i;
    assign s_priv = priv_i;
    assign s_virt = virt_i;
    assign s_mie  = mie_i;
    assign s_sie  = sie_i;
  end

  // R1
  cand_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o) |-> s_cand[cause_o]);

  // R2
  m_tier_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o && target_o == 2'b11 && s_priv == 2'b11) |-> s_mie);

  // R4
  vs_tier_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o && target_o == 2'b10) |-> (s_virt && s_priv != 2'b11 && s_priv != 2'b10));

  // R4
  vs_tier_sie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o && target_o == 2'b10 && s_priv == 2'b01) |-> s_sie);

  // R5
  m_tier_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o && target_o == 2'b11) |-> !s_md[cause_o]);

  // R5
  hs_tier_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o && target_o == 2'b01) |-> (s_md[cause_o] && !s_hd[cause_o]));

  // R5
  vs_tier_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && take_o && target_o == 2'b10) |-> (s_md[cause_o] && s_hd[cause_o]));

  // R7
  target_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (target_o != 2'b00));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0 && target_o == 2'b00));

  // R9
  no_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && s_priv == 2'b10) |-> !take_o);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    (REG_OUT && !rst_n) |-> (!take_o && cause_o == '0 && target_o == 2'b00));

endmodule

bind hyp_irq_router hir_route_chk #(.IRQ_W(IRQ_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/hyp_irq_router_tb.sv
`timescale 1ns/1ps
module hyp_irq_router_tb;

  localparam int W  = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  pend, en, md, hd;
  logic [1:0]    priv;
  logic          virt, mie, sie;
  logic          take;
  logic [CW-1:0] cause;
  logic [1:0]    tgt;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hyp_irq_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .irq_pend_i(pend), .irq_en_i(en), .mdeleg_i(md), .hdeleg_i(hd),
    .priv_i(priv), .virt_i(virt), .mie_i(mie), .sie_i(sie),
    .take_o(take), .cause_o(cause), .target_o(tgt)
  );

  task automatic check(string tag, logic et, logic [CW-1:0] ec, logic [1:0] eg);
    n_vec++;
    if (take !== et || cause !== ec || tgt !== eg) begin
      n_miss++;
      $display("FAIL %s: got take=%b cause=%0d target=%b, expected take=%b cause=%0d target=%b",
               tag, take, cause, tgt, et, ec, eg);
    end
  endtask

  task automatic drive(logic [W-1:0] p, logic [W-1:0] e, logic [W-1:0] m, logic [W-1:0] h,
                       logic [1:0] pr, logic v, logic mi, logic si);
    pend = p; en = e; md = m; hd = h; priv = pr; virt = v; mie = mi; sie = si;
  endtask

  // Drive at a falling edge, let one rising edge capture, sample at the next falling edge
  task automatic apply(logic [W-1:0] p, logic [W-1:0] e, logic [W-1:0] m, logic [W-1:0] h,
                       logic [1:0] pr, logic v, logic mi, logic si,
                       string tag, logic et, logic [CW-1:0] ec, logic [1:0] eg);
    @(negedge clk);
    drive(p, e, m, h, pr, v, mi, si);
    @(negedge clk);
    check(tag, et, ec, eg);
  endtask

  // Independent reference written from the requirements
  function automatic logic [6:0] model(logic [W-1:0] p, logic [W-1:0] e, logic [W-1:0] m,
                                       logic [W-1:0] h, logic [1:0] pr, logic v,
                                       logic mi, logic si);
    logic ok_m, ok_hs, ok_vs;
    ok_m  = (pr == 2'b00) || (pr == 2'b01) || (pr == 2'b11 && mi);
    ok_hs = (pr != 2'b10) && (v || pr == 2'b00 || (pr == 2'b01 && si));
    ok_vs = v && (pr == 2'b00 || (pr == 2'b01 && si));
    for (int i = 0; i < W; i++) begin
      if (p[i] && e[i]) begin
        if (!m[i] && ok_m)              return {1'b1, 4'(i), 2'b11};
        if (m[i] && !h[i] && ok_hs)     return {1'b1, 4'(i), 2'b01};
        if (m[i] && h[i] && ok_vs)      return {1'b1, 4'(i), 2'b10};
      end
    end
    return 7'd0;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    drive(16'h0080, 16'hFFFF, 16'h0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 reset", 1'b0, 4'd0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 1'b1, 4'd7, 2'b11);
  endtask

  task automatic t_m_tier();
    apply(16'h0080, 16'hFFFF, 16'h0, 16'h0, 2'b11, 1'b0, 1'b0, 1'b1, "R2 M mie=0", 1'b0, 4'd0, 2'b00);
    apply(16'h0080, 16'hFFFF, 16'h0, 16'h0, 2'b11, 1'b0, 1'b1, 1'b0, "R2 M mie=1", 1'b1, 4'd7, 2'b11);
    apply(16'h0080, 16'hFFFF, 16'h0, 16'h0, 2'b01, 1'b0, 1'b0, 1'b0, "R2 S below M", 1'b1, 4'd7, 2'b11);
    apply(16'h0080, 16'h0000, 16'h0, 16'h0, 2'b00, 1'b0, 1'b1, 1'b1, "R1 not enabled", 1'b0, 4'd0, 2'b00);
  endtask

  task automatic t_hs_tier();
    apply(16'h0020, 16'hFFFF, 16'h0020, 16'h0, 2'b01, 1'b0, 1'b1, 1'b0, "R3 S sie=0", 1'b0, 4'd0, 2'b00);
    apply(16'h0020, 16'hFFFF, 16'h0020, 16'h0, 2'b01, 1'b0, 1'b0, 1'b1, "R3 S sie=1", 1'b1, 4'd5, 2'b01);
    apply(16'h0020, 16'hFFFF, 16'h0020, 16'h0, 2'b01, 1'b1, 1'b0, 1'b0, "R3 VS ignores sie", 1'b1, 4'd5, 2'b01);
    apply(16'h0020, 16'hFFFF, 16'h0020, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, "R3 U", 1'b1, 4'd5, 2'b01);
    apply(16'h0020, 16'hFFFF, 16'h0020, 16'h0, 2'b11, 1'b0, 1'b1, 1'b1, "R3 M blocks", 1'b0, 4'd0, 2'b00);
  endtask

  task automatic t_vs_tier();
    apply(16'h0004, 16'hFFFF, 16'h0004, 16'h0004, 2'b01, 1'b0, 1'b1, 1'b1, "R4 virt off", 1'b0, 4'd0, 2'b00);
    apply(16'h0004, 16'hFFFF, 16'h0004, 16'h0004, 2'b01, 1'b1, 1'b1, 1'b0, "R4 VS sie=0", 1'b0, 4'd0, 2'b00);
    apply(16'h0004, 16'hFFFF, 16'h0004, 16'h0004, 2'b01, 1'b1, 1'b0, 1'b1, "R4 VS sie=1", 1'b1, 4'd2, 2'b10);
    apply(16'h0004, 16'hFFFF, 16'h0004, 16'h0004, 2'b00, 1'b1, 1'b0, 1'b0, "R4 VU", 1'b1, 4'd2, 2'b10);
  endtask

  task automatic t_guest_lines_host();
    apply(16'h0400, 16'hFFFF, 16'h0, 16'h0, 2'b01, 1'b0, 1'b0, 1'b0, "R1 line10 to M", 1'b1, 4'd10, 2'b11);
    apply(16'h0040, 16'hFFFF, 16'h0040, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, "R1 line6 to HS", 1'b1, 4'd6, 2'b01);
  endtask

  task automatic t_deleg();
    apply(16'h0008, 16'hFFFF, 16'h0, 16'h0008, 2'b11, 1'b0, 1'b1, 1'b0, "R5 hdeleg alone", 1'b1, 4'd3, 2'b11);
    apply(16'h0202, 16'hFFFF, 16'h0002, 16'h0002, 2'b01, 1'b0, 1'b0, 1'b1, "R5 R6 gated low line skipped", 1'b1, 4'd9, 2'b11);
  endtask

  task automatic t_priority();
    apply(16'h0A40, 16'hFFFF, 16'h0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, "R6 lowest", 1'b1, 4'd6, 2'b11);
    apply(16'h8000, 16'hFFFF, 16'h8000, 16'h8000, 2'b00, 1'b1, 1'b0, 1'b0, "R6 R7 top line VS", 1'b1, 4'd15, 2'b10);
    apply(16'h0001, 16'hFFFF, 16'h0001, 16'h0, 2'b00, 1'b1, 1'b0, 1'b0, "R6 R7 line0 HS", 1'b1, 4'd0, 2'b01);
  endtask

  task automatic t_no_priv();
    apply(16'hFFFF, 16'hFFFF, 16'h0F0F, 16'h00FF, 2'b10, 1'b1, 1'b1, 1'b1, "R9 R8 code 10", 1'b0, 4'd0, 2'b00);
  endtask

  task automatic t_latency();
    apply(16'h0010, 16'hFFFF, 16'h0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, "R10 setup", 1'b1, 4'd4, 2'b11);
    @(negedge clk);
    drive(16'h0800, 16'hFFFF, 16'h0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0);
    #1;
    check("R10 holds until edge", 1'b1, 4'd4, 2'b11);
    @(negedge clk);
    check("R10 updates after edge", 1'b1, 4'd11, 2'b11);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] p, e, m, h;
      logic [1:0]   pr;
      logic [2:0]   b;
      logic [6:0]   ex;
      p  = W'($urandom & $urandom & $urandom);
      e  = W'($urandom | $urandom);
      m  = W'($urandom);
      h  = W'($urandom);
      pr = 2'($urandom);
      b  = 3'($urandom);
      ex = model(p, e, m, h, pr, b[0], b[1], b[2]);
      apply(p, e, m, h, pr, b[0], b[1], b[2], "R1-sweep R5 R6", ex[6], ex[5:2], ex[1:0]);
    end
  endtask

  initial begin
    t_reset();
    t_m_tier();
    t_hs_tier();
    t_vs_tier();
    t_guest_lines_host();
    t_deleg();
    t_priority();
    t_no_priv();
    t_latency();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

endmodule